// File: doc/BRIEF.md
# Receive Clock Loss Fallback Monitor

This block watches the bit clock that arrives from a line framer and decides, in the faster system clock domain, whether that clock is still alive. The clock is brought in through a synchronizer, and every transition it shows restarts a timeout window. If the window runs out, the clock is declared lost and a live status bit goes high. A sticky flag also records the event until software clears it with a write-one pulse.

When a loss is declared and the fallback enable is set, the block stops using the framer clock. The bit timing now comes from a reference clock divided by four. The received bytes are replaced by a programmed fill byte, emitted once per eight fallback bit periods, so that a downstream segmenter keeps receiving a steady byte stream. The reference clock is shared with the clock recovery logic elsewhere; this block only samples it.

Once the framer clock shows a run of uninterrupted edges again, normal operation resumes. The hand-back takes place only at a byte boundary of the fallback stream.

Top module: `rx_clk_fallback`

## Requirements
- R1: `clk_lost` rises once the synchronized receive clock shows no rising or falling edge for 23 consecutive system cycles. A level change on `rx_clk_in` becomes visible to the timer three system cycles after it is sampled (two synchronizer flops plus one edge-history flop), so edges spaced 23 cycles apart never cause a loss and edges spaced 24 cycles apart do.
- R2: After a loss, `clk_lost` falls only after 8 consecutive receive clock edges with no new timeout in between; 7 edges are not enough. With fallback disabled, it falls within a few cycles of the 8th edge.
- R3: While lost with `fb_en`=1, `fb_active` is 1 and `bit_tick` pulses once per four rising edges of the synchronized `ref_clk_in`; the divide-by-four counter runs freely from reset.
- R4: While in fallback, `out_vld` pulses once every 8 `bit_tick` pulses and carries `fill_byte` on `out_byte`; `rx_vld` and `rx_byte` are ignored.
- R5: With `fb_en`=0, `fb_active` stays 0 even when the clock is lost, and the output keeps passing the received bytes.
- R6: `loss_seen` is set when a loss is declared and cleared by a cycle with `loss_clr`=1. When both fall in the same cycle, the set wins.
- R7: Fallback ends only at a byte boundary, so the number of fallback `bit_tick` pulses in one episode is a multiple of 8.
- R8: In normal operation, `out_vld`/`out_byte` equal `rx_vld`/`rx_byte` of the previous cycle, and `bit_tick` pulses once per rising edge of the receive clock.
- R9: Reset is synchronous and active low; during reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than both sampled clocks |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_clk_in | input | 1 | Framer receive bit clock (asynchronous) |
| ref_clk_in | input | 1 | Reference clock (asynchronous) |
| rx_byte | input | 8 | Received payload byte, system domain |
| rx_vld | input | 1 | Qualifies `rx_byte` |
| fb_en | input | 1 | Enables fallback substitution |
| fill_byte | input | 8 | Byte sent while in fallback |
| loss_clr | input | 1 | Write-one-to-clear for `loss_seen` |
| bit_tick | output | 1 | One pulse per bit period from the selected source |
| out_byte | output | 8 | Payload byte to the segmenter |
| out_vld | output | 1 | Qualifies `out_byte` |
| clk_lost | output | 1 | Live loss status |
| fb_active | output | 1 | Fallback substitution in effect |
| loss_seen | output | 1 | Sticky loss record |

## Verification
A loss declaration and a software clear of the sticky flag can land in the same system cycle. The bench provokes this by stopping the receive clock at a known cycle. It then sweeps a single-cycle `loss_clr` pulse across offsets 20 to 30 cycles after the last edge. The flag must read 1 for every offset up to and including 25, where the clear coincides with the declaration, and 0 for every later offset.

// File: rtl/rlm_pkg.sv
// Shared types for the receive clock loss fallback monitor.
// Assumes nothing beyond a standard SystemVerilog compile.
package rlm_pkg;
    // Which source drives the bit timing and payload path.
    typedef enum logic [0:0] {
        SRC_RX  = 1'b0,
        SRC_REF = 1'b1
    } tick_src_e;
endpackage

// File: rtl/rlm_edge_sync.sv
// Brings an asynchronous clock-like signal into the system domain through
// a STAGES-deep flop chain and reports any level change after it.
// Assumes the system clock samples each level for at least one cycle.
module rlm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic any_edge
);
    logic [STAGES-1:0] chain_q;
    logic              hist_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First synchronizer flop captures the raw input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= async_in;
                end
            end else begin : g_next
                // Later flops shift the value along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // History flop keeps the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= chain_q[STAGES-1];
    end

    assign level    = chain_q[STAGES-1];
    assign any_edge = chain_q[STAGES-1] ^ hist_q;
endmodule

// File: rtl/rlm_loss_timer.sv
// Counts system cycles since the last receive clock edge and flags a timeout
// after TIMEOUT_CYC edgeless cycles; while lost, counts edges toward recovery.
// Assumes edge_seen is a single-cycle pulse per synchronized transition.
module rlm_loss_timer #(
    parameter  int TIMEOUT_CYC   = 23,
    parameter  int RECOVER_EDGES = 8,
    localparam int CNT_W         = $clog2(TIMEOUT_CYC + 1),
    localparam int REC_W         = $clog2(RECOVER_EDGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_seen,
    input  logic             lost,
    output logic             timeout_pulse,
    output logic             rec_done,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(TIMEOUT_CYC);
    localparam logic [REC_W-1:0] REC_FULL = REC_W'(RECOVER_EDGES);

    logic [REC_W-1:0] rec_q;

    // Edgeless-cycle counter, saturating once the timeout has fired.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (edge_seen)       cnt_q <= '0;
        else if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
    end

    // Consecutive-edge counter used to leave the lost state.
    always_ff @(posedge clk) begin
        if (!rst_n)                           rec_q <= '0;
        else if (timeout_pulse || !lost)      rec_q <= '0;
        else if (edge_seen && rec_q != REC_FULL) rec_q <= rec_q + 1'b1;
    end

    assign timeout_pulse = !edge_seen && (cnt_q == CNT_LAST);
    assign rec_done      = (rec_q == REC_FULL);
endmodule

// File: rtl/rlm_ref_div.sv
// Free-running divider on synchronized reference rising edges, plus the
// bit-position counter of the fallback byte stream.
// Assumes REF_DIV and BITS_PER_BYTE are powers of two of at least 2.
module rlm_ref_div #(
    parameter  int REF_DIV       = 4,
    parameter  int BITS_PER_BYTE = 8,
    localparam int DIV_W         = $clog2(REF_DIV),
    localparam int BIT_W         = $clog2(BITS_PER_BYTE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_rise,
    input  logic             run,
    output logic             fb_tick,
    output logic             byte_done,
    output logic [BIT_W-1:0] bit_idx
);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(REF_DIV - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS_PER_BYTE - 1);

    logic [DIV_W-1:0] div_q;

    // Divider advances on every reference rising edge, never stops.
    always_ff @(posedge clk) begin
        if (!rst_n)        div_q <= '0;
        else if (ref_rise) div_q <= div_q + 1'b1;
    end

    // Bit position inside the fallback byte, held at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) bit_idx <= '0;
        else if (fb_tick)   bit_idx <= (bit_idx == BIT_LAST) ? '0 : bit_idx + 1'b1;
    end

    assign fb_tick   = ref_rise && (div_q == DIV_LAST);
    assign byte_done = run && fb_tick && (bit_idx == BIT_LAST);
endmodule

// File: rtl/rx_clk_fallback.sv
// Top of the receive clock loss fallback monitor. Declares loss of the
// framer clock, optionally substitutes reference timing and a fill byte,
// and hands back to the framer clock at a byte boundary.
// Assumes rx_byte/rx_vld are already in the system clock domain.
module rx_clk_fallback #(
    parameter int DATA_W        = 8,
    parameter int SYNC_STAGES   = 2,
    parameter int TIMEOUT_CYC   = 23,
    parameter int RECOVER_EDGES = 8,
    parameter int REF_DIV       = 4,
    parameter int BITS_PER_BYTE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_clk_in,
    input  logic              ref_clk_in,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_vld,
    input  logic              fb_en,
    input  logic [DATA_W-1:0] fill_byte,
    input  logic              loss_clr,
    output logic              bit_tick,
    output logic [DATA_W-1:0] out_byte,
    output logic              out_vld,
    output logic              clk_lost,
    output logic              fb_active,
    output logic              loss_seen
);
    import rlm_pkg::*;

    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam int BIT_W = $clog2(BITS_PER_BYTE);

    logic             rx_level, rx_edge, rx_rise;
    logic             ref_level, ref_edge, ref_rise;
    logic             timeout_pulse, rec_done;
    logic [CNT_W-1:0] tmr_cnt;
    logic             fb_tick, byte_done;
    logic [BIT_W-1:0] bit_idx;
    logic             lost_q, fb_q, sticky_q;
    logic             exit_ok, lost_d, fb_d;
    tick_src_e        src;

    rlm_edge_sync #(.STAGES(SYNC_STAGES)) u_rx_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rx_clk_in),
        .level    (rx_level),
        .any_edge (rx_edge)
    );

    rlm_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ref_clk_in),
        .level    (ref_level),
        .any_edge (ref_edge)
    );

    assign rx_rise  = rx_edge & rx_level;
    assign ref_rise = ref_edge & ref_level;

    rlm_loss_timer #(
        .TIMEOUT_CYC   (TIMEOUT_CYC),
        .RECOVER_EDGES (RECOVER_EDGES)
    ) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .edge_seen     (rx_edge),
        .lost          (lost_q),
        .timeout_pulse (timeout_pulse),
        .rec_done      (rec_done),
        .cnt_q         (tmr_cnt)
    );

    rlm_ref_div #(
        .REF_DIV       (REF_DIV),
        .BITS_PER_BYTE (BITS_PER_BYTE)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_rise  (ref_rise),
        .run       (fb_q),
        .fb_tick   (fb_tick),
        .byte_done (byte_done),
        .bit_idx   (bit_idx)
    );

    // Next-state logic for loss and fallback; timeout outranks recovery.
    always_comb begin
        exit_ok = lost_q && rec_done && (!fb_q || (bit_idx == '0 && !fb_tick));
        if (timeout_pulse)  lost_d = 1'b1;
        else if (exit_ok)   lost_d = 1'b0;
        else                lost_d = lost_q;
        fb_d = lost_d && fb_en;
        src  = fb_q ? SRC_REF : SRC_RX;
    end

    // Loss and fallback state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lost_q <= 1'b0;
            fb_q   <= 1'b0;
        end else begin
            lost_q <= lost_d;
            fb_q   <= fb_d;
        end
    end

    // Sticky loss record; a new loss outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)             sticky_q <= 1'b0;
        else if (timeout_pulse) sticky_q <= 1'b1;
        else if (loss_clr)      sticky_q <= 1'b0;
    end

    // Output stage: timing and payload from the selected source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_tick <= 1'b0;
            out_vld  <= 1'b0;
            out_byte <= '0;
        end else if (src == SRC_REF) begin
            bit_tick <= fb_tick;
            out_vld  <= byte_done;
            if (byte_done) out_byte <= fill_byte;
        end else begin
            bit_tick <= rx_rise;
            out_vld  <= rx_vld;
            if (rx_vld) out_byte <= rx_byte;
        end
    end

    assign clk_lost  = lost_q;
    assign fb_active = fb_q;
    assign loss_seen = sticky_q;
endmodule

// File: rtl/rlm_checker.sv
// Temporal checks for rx_clk_fallback, attached by bind below.
// Assumes it sees the top's ports plus its timer count and bit position.
module rlm_checker #(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 5,
    parameter int BIT_W       = 3,
    parameter int TIMEOUT_CYC = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fb_en,
    input logic [DATA_W-1:0] fill_byte,
    input logic [DATA_W-1:0] out_byte,
    input logic              out_vld,
    input logic              clk_lost,
    input logic              fb_active,
    input logic              loss_seen,
    input logic [CNT_W-1:0]  tmr_cnt,
    input logic [BIT_W-1:0]  bit_idx
);
    AST_LOSS_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_lost) |-> $past(tmr_cnt) == CNT_W'(TIMEOUT_CYC - 1)); // R1

    AST_FILL_IN_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && $past(fb_active)) |-> out_byte == $past(fill_byte)); // R4

    AST_NO_FALLBACK_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fb_en) |-> !fb_active); // R5

    AST_STICKY_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_lost) |-> loss_seen); // R6

    AST_EXIT_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fb_active) && $past(fb_en)) |-> $past(bit_idx) == '0); // R7
endmodule

bind rx_clk_fallback rlm_checker #(
    .DATA_W      (DATA_W),
    .CNT_W       (CNT_W),
    .BIT_W       (BIT_W),
    .TIMEOUT_CYC (TIMEOUT_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fb_en     (fb_en),
    .fill_byte (fill_byte),
    .out_byte  (out_byte),
    .out_vld   (out_vld),
    .clk_lost  (clk_lost),
    .fb_active (fb_active),
    .loss_seen (loss_seen),
    .tmr_cnt   (tmr_cnt),
    .bit_idx   (bit_idx)
);

// File: tb/test_rx_clk_fallback.sv
`timescale 1ns/1ps
module test_rx_clk_fallback;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_clk = 1'b0;
    logic       ref_clk;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_vld = 1'b0;
    logic       fb_en = 1'b0;
    logic [7:0] fill_byte = 8'h3C;
    logic       loss_clr = 1'b0;
    logic       bit_tick, out_vld, clk_lost, fb_active, loss_seen;
    logic [7:0] out_byte;

    int checks = 0;
    int errors = 0;
    int ref_half = 2;
    int exp_gap = 16;

    // monitor state
    int  cyc = 0, mon_ticks = 0, mon_bytes = 0, bad_fill = 0, bad_gap = 0, fa_cycles = 0;
    int  last_tick = -1;
    logic fa_q = 1'b0;

    rx_clk_fallback i_rx_clk_fallback (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_clk_in  (rx_clk),
        .ref_clk_in (ref_clk),
        .rx_byte    (rx_byte),
        .rx_vld     (rx_vld),
        .fb_en      (fb_en),
        .fill_byte  (fill_byte),
        .loss_clr   (loss_clr),
        .bit_tick   (bit_tick),
        .out_byte   (out_byte),
        .out_vld    (out_vld),
        .clk_lost   (clk_lost),
        .fb_active  (fb_active),
        .loss_seen  (loss_seen)
    );

    always #10 clk = ~clk;

    // reference clock generator, half period ref_half system cycles
    initial begin
        int rc;
        rc = 0;
        ref_clk = 1'b0;
        forever begin
            @(negedge clk);
            rc++;
            if (rc >= ref_half) begin
                rc = 0;
                ref_clk = ~ref_clk;
            end
        end
    end

    // fallback stream monitor (uses fallback state of the previous cycle)
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            fa_q = 1'b0;
            last_tick = -1;
        end else begin
            if (fb_active) fa_cycles++;
            if (fa_q) begin
                if (bit_tick) begin
                    mon_ticks++;
                    if (last_tick >= 0 && (cyc - last_tick) != exp_gap) bad_gap++;
                    last_tick = cyc;
                end
                if (out_vld) begin
                    mon_bytes++;
                    if (out_byte != fill_byte) bad_fill++;
                end
            end else begin
                last_tick = -1;
            end
            fa_q = fb_active;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog expired: actual hung run, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input bit check_outs);
        rst_n = 1'b0;
        rx_clk = 1'b0;
        loss_clr = 1'b0;
        repeat (5) @(negedge clk);
        if (check_outs) begin
            chk({bit_tick, out_vld, clk_lost, fb_active, loss_seen} == 5'b0, "R9",
                "status outputs in reset", {bit_tick, out_vld, clk_lost, fb_active, loss_seen}, 0);
            chk(out_byte == 8'h00, "R9", "out_byte in reset", out_byte, 0);
        end
        rst_n = 1'b1;
    endtask

    task automatic run_rx(input int half, input int toggles);
        for (int t = 0; t < toggles; t++) begin
            rx_clk = ~rx_clk;
            repeat (half) @(negedge clk);
        end
    endtask

    initial begin
        int m0_t, m0_b, m0_f, m0_g, m0_a, rises, ticks;
        do_reset(1'b1);

        // R1: sweep of edge spacing around the 23-cycle window
        for (int p = 16; p <= 30; p++) begin
            fb_en = 1'b0;
            do_reset(1'b0);
            run_rx(p, 6);
            chk(loss_seen == (p >= 24), "R1", $sformatf("loss at spacing %0d", p),
                loss_seen, (p >= 24));
        end

        // R8: pass-through of bytes and rx rising-edge ticks
        fb_en = 1'b1;
        do_reset(1'b0);
        rises = 0;
        ticks = 0;
        for (int i = 0; i < 40; i++) begin
            logic [7:0] b;
            logic       v;
            b = 8'(i * 7 + 1);
            v = (i % 3) != 0;
            if (i % 2 == 0) begin
                rx_clk = ~rx_clk;
                if (rx_clk) rises++;
            end
            rx_byte = b;
            rx_vld = v;
            @(negedge clk);
            if (bit_tick) ticks++;
            chk(out_vld == v && (!v || out_byte == b), "R8", $sformatf("pass-through %0d", i),
                {out_vld, out_byte}, {v, b});
        end
        rx_vld = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (bit_tick) ticks++;
        end
        chk(ticks == rises, "R8", "normal bit_tick count", ticks, rises);

        // R3, R4, R7, R2: fallback episodes for several reference rates
        for (int h = 1; h <= 3; h++) begin
            ref_half = h;
            exp_gap = 8 * h;
            fb_en = 1'b1;
            rx_byte = 8'hA5;
            rx_vld = 1'b1;
            do_reset(1'b0);
            #1;
            m0_t = mon_ticks; m0_b = mon_bytes; m0_f = bad_fill; m0_g = bad_gap;
            @(negedge clk);
            run_rx(3, 4);
            repeat (40 + 3 * 64 * h) @(negedge clk);
            chk(clk_lost == 1'b1 && fb_active == 1'b1, "R3", $sformatf("fallback entered h=%0d", h),
                {clk_lost, fb_active}, 3);
            #1;
            chk(mon_bytes - m0_b >= 2, "R4", $sformatf("fill bytes emitted h=%0d", h),
                mon_bytes - m0_b, 2);
            chk(bad_gap == m0_g, "R3", $sformatf("tick spacing 8*%0d", h), bad_gap - m0_g, 0);
            for (int k = 0; k < 400 && fb_active; k++) run_rx(3, 1);
            #1;
            chk(fb_active == 1'b0 && clk_lost == 1'b0, "R2", $sformatf("recovered h=%0d", h),
                {clk_lost, fb_active}, 0);
            chk((mon_ticks - m0_t) == 8 * (mon_bytes - m0_b), "R7",
                $sformatf("ticks per episode h=%0d", h), mon_ticks - m0_t, 8 * (mon_bytes - m0_b));
            chk(bad_fill == m0_f, "R4", $sformatf("fill value, rx ignored h=%0d", h),
                bad_fill - m0_f, 0);
            @(negedge clk);
        end
        ref_half = 2;
        exp_gap = 16;

        // R5: loss with fallback disabled keeps passing rx data
        fb_en = 1'b0;
        rx_byte = 8'h5A;
        rx_vld = 1'b1;
        do_reset(1'b0);
        #1;
        m0_a = fa_cycles;
        @(negedge clk);
        run_rx(3, 4);
        repeat (200) @(negedge clk);
        chk(clk_lost == 1'b1, "R5", "lost while disabled", clk_lost, 1);
        chk(out_vld == 1'b1 && out_byte == 8'h5A, "R5", "no substitution", out_byte, 8'h5A);
        #1;
        chk(fa_cycles == m0_a, "R5", "fb_active never set", fa_cycles - m0_a, 0);

        // R2: seven edges keep the loss, the eighth ends it
        @(negedge clk);
        run_rx(3, 7);
        chk(clk_lost == 1'b1, "R2", "still lost after 7 edges", clk_lost, 1);
        run_rx(6, 1);
        chk(clk_lost == 1'b0, "R2", "recovered after 8 edges", clk_lost, 0);
        rx_vld = 1'b0;

        // R6: clear works while clock runs
        repeat (40) @(negedge clk);
        chk(loss_seen == 1'b1, "R6", "sticky after loss", loss_seen, 1);
        loss_clr = 1'b1;
        @(negedge clk);
        loss_clr = 1'b0;
        @(negedge clk);
        chk(loss_seen == 1'b0, "R6", "cleared by write-one", loss_seen, 0);

        // R6: clear pulse swept across the declaration cycle (set wins at 25)
        for (int d = 20; d <= 30; d++) begin
            do_reset(1'b0);
            run_rx(3, 9);
            rx_clk = ~rx_clk;
            repeat (d) @(negedge clk);
            loss_clr = 1'b1;
            @(negedge clk);
            loss_clr = 1'b0;
            repeat (5) @(negedge clk);
            chk(loss_seen == (d <= 25), "R6", $sformatf("clear at offset %0d", d),
                loss_seen, (d <= 25));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule